// File: doc/BRIEF.md
# Removable-Card Slot Status and Event Register Block

This block sits on a simple word-indexed register bus and serves one removable-card slot. It gives software two pieces of slot state: the live write-protect level of the inserted card, and a sticky record that a card was inserted. The sticky record also drives a single interrupt line, so an insertion wakes software even if the insert pulse is short.

Software reads the status word to learn both states. It acknowledges an insertion by writing 1 to the insert bit, which clears the record and drops the interrupt. Two constant words identify the block and describe its address decode. A flash-programming word reads as zero and ignores writes. Any other index, and any write to the identity word, is flagged as a bad access and reads as zero.

The bus is a plain single-cycle register port with no back-pressure. A read returns data combinationally in the cycle `bus_sel` is high. A write takes effect at the rising clock edge that ends that cycle. Both slot inputs are assumed to be synchronous to `clk`.

Top module: `cardslot_ctrl`

## Requirements
- R1: A read of index 0 returns 0x41034003, a read of index 3 returns 0x00000011, and a read of index 1 returns 0. None of these reads raises `bus_err`.
- R2: Bit 0 of the status word (index 2) always equals `wp_level` in the same cycle, with no clock delay.
- R3: If `card_in_level` is high at a rising edge, status bit 3 and `card_irq` are 1 from that edge on. A low `card_in_level` never clears them.
- R4: A write to index 2 with write-data bit 3 = 1 clears status bit 3 at that edge, and `card_irq` is 0 from then on. A write to index 2 with bit 3 = 0 changes nothing.
- R5: If `card_in_level` is high in the same cycle as a clearing write, the set wins and status bit 3 stays 1.
- R6: After reset, status bit 3 is 0 and `card_irq` is 0. Status bits other than 0 and 3 always read 0.
- R7: Writes to index 1 and index 3 are accepted without `bus_err` and change no readable state and not `card_irq`.
- R8: An access to an index of 4 or above, or a write to index 0, asserts `bus_err` in that cycle. Such an access reads 0 and changes no state.
- R9: `card_irq` equals status bit 3 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_idx | input | ADDR_W | Word index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while bus_sel is high |
| bus_err | output | 1 | Bad-access flag for the current access |
| wp_level | input | 1 | Write-protect level from the slot |
| card_in_level | input | 1 | Card-insert level from the slot |
| card_irq | output | 1 | Insertion interrupt, high until acknowledged |

## Verification
The only internal state is the insert latch, so a fault there shows up on `card_irq` one edge after the stimulus. It also shows up in bit 3 of the next status read. A latch that misses a set, drops a set on a clear collision, or clears on a low input therefore shows within one cycle. The write-protect path and the decode have no state, so an error in either appears on `bus_rdata` or `bus_err` in the same cycle as the access.

// File: rtl/cslot_pkg.sv
package cslot_pkg;
  // word indices as seen by software
  localparam int IDX_ID     = 0;
  localparam int IDX_FLASH  = 1;
  localparam int IDX_STATUS = 2;
  localparam int IDX_DECODE = 3;
  localparam int NUM_REGS   = 4;

  // status bit positions decoded by software
  localparam int WP_BIT   = 0;
  localparam int CARD_BIT = 3;

  localparam logic [31:0] ID_VALUE     = 32'h4103_4003;
  localparam logic [31:0] DECODE_VALUE = 32'h0000_0011;

  typedef struct packed {
    logic id;
    logic flash;
    logic status;
    logic decode;
    logic bad;
  } hit_t;
endpackage

// File: rtl/cslot_decode.sv
module cslot_decode
  import cslot_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] idx_i,
  output hit_t              hit_o
);
  logic in_range;

  assign in_range = idx_i < ADDR_W'(NUM_REGS);

  always_comb begin
    hit_o        = '0;
    hit_o.id     = sel_i && (idx_i == ADDR_W'(IDX_ID)) && !wr_i;
    hit_o.flash  = sel_i && (idx_i == ADDR_W'(IDX_FLASH));
    hit_o.status = sel_i && (idx_i == ADDR_W'(IDX_STATUS));
    hit_o.decode = sel_i && (idx_i == ADDR_W'(IDX_DECODE));
    // the identity word is read-only: writing it is a bad access
    hit_o.bad    = sel_i && (!in_range || (wr_i && idx_i == ADDR_W'(IDX_ID)));
  end
endmodule

// File: rtl/cslot_sticky.sv
module cslot_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set has priority over clear
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/cslot_rdmux.sv
module cslot_rdmux
  import cslot_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  hit_t              hit_i,
  input  logic              wp_i,
  input  logic              card_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] status_word;

  always_comb begin
    status_word           = '0;
    status_word[WP_BIT]   = wp_i;
    status_word[CARD_BIT] = card_i;
  end

  always_comb begin
    rdata_o = '0;
    if (hit_i.id)     rdata_o = DATA_W'(ID_VALUE);
    if (hit_i.status) rdata_o = status_word;
    if (hit_i.decode) rdata_o = DATA_W'(DECODE_VALUE);
    // the flash word and bad accesses read as zero
  end
endmodule

// File: rtl/cardslot_ctrl.sv
module cardslot_ctrl
  import cslot_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_idx,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic              wp_level,
  input  logic              card_in_level,
  output logic              card_irq
);
  hit_t hit;
  logic ack_wr;
  logic card_q;
  logic unused_wdata;

  cslot_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel_i (bus_sel),
    .wr_i  (bus_wr),
    .idx_i (bus_idx),
    .hit_o (hit)
  );

  assign ack_wr = hit.status && bus_wr && bus_wdata[CARD_BIT];

  cslot_sticky u_card (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (card_in_level),
    .clr_i (ack_wr),
    .q_o   (card_q)
  );

  cslot_rdmux #(.DATA_W(DATA_W)) u_rd (
    .hit_i   (hit),
    .wp_i    (wp_level),
    .card_i  (card_q),
    .rdata_o (bus_rdata)
  );

  assign bus_err      = hit.bad;
  assign card_irq     = card_q;
  assign unused_wdata = ^bus_wdata;
endmodule

// File: rtl/cslot_chk.sv
module cslot_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_idx,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_err,
  input logic              wp_level,
  input logic              card_in_level,
  input logic              card_irq
);
  logic rd_status, clr_req, hi_idx;
  assign rd_status = bus_sel && !bus_wr && bus_idx == ADDR_W'(2);
  assign clr_req   = bus_sel && bus_wr && bus_idx == ADDR_W'(2) && bus_wdata[3];
  assign hi_idx    = bus_sel && bus_idx >= ADDR_W'(4);

  p_wp_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status |-> bus_rdata[0] == wp_level);
  p_card_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    card_in_level |=> card_irq);
  p_card_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!card_in_level && !clr_req) |=> $stable(card_irq));
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !card_in_level) |=> !card_irq);
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && card_in_level) |=> card_irq);
  p_zero_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status |-> (bus_rdata & ~DATA_W'(9)) == '0);
  p_bad_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hi_idx |-> (bus_err && bus_rdata == '0));
  p_irq_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status |-> bus_rdata[3] == card_irq);
endmodule

bind cardslot_ctrl cslot_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_err(bus_err), .wp_level(wp_level), .card_in_level(card_in_level),
  .card_irq(card_irq)
);

// File: tb/tb_cardslot_ctrl.sv
module tb_cardslot_ctrl;
  localparam int AW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_idx = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          bus_err;
  logic          wp_level = 1'b0, card_in_level = 1'b0;
  logic          card_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cardslot_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input int idx, output logic [DW-1:0] d, output logic e);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_idx = AW'(idx);
    #2; d = bus_rdata; e = bus_err;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wr(input int idx, input logic [DW-1:0] v, output logic e);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_idx = AW'(idx); bus_wdata = v;
    #2; e = bus_err;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic pulse_card();
    @(negedge clk); card_in_level = 1'b1;
    @(negedge clk); card_in_level = 1'b0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d; logic e;
    check("R6 irq after reset", DW'(card_irq), 0);
    rd(2, d, e);
    check("R6 status after reset", d, 0);
  endtask

  task automatic t_constants();
    logic [DW-1:0] d; logic e;
    rd(0, d, e); check("R1 id word", d, 32'h4103_4003); check("R1 id err", DW'(e), 0);
    rd(1, d, e); check("R1 flash word", d, 0);
    rd(3, d, e); check("R1 decode word", d, 32'h11);
  endtask

  task automatic t_wp();
    logic [DW-1:0] d; logic e;
    wp_level = 1'b1; rd(2, d, e); check("R2 wp high", d, 32'h1);
    wp_level = 1'b0; rd(2, d, e); check("R2 wp low", d, 32'h0);
  endtask

  task automatic t_insert();
    logic [DW-1:0] d; logic e;
    pulse_card();
    check("R3 irq after insert", DW'(card_irq), 1);
    repeat (3) @(negedge clk);
    check("R3 irq held after input low", DW'(card_irq), 1);
    rd(2, d, e); check("R9 status bit3 with irq", d, 32'h8);
    wr(2, 32'hFFFF_FFF7, e);
    check("R4 write bit3=0 keeps irq", DW'(card_irq), 1);
    wr(2, 32'h8, e);
    check("R4 irq after ack", DW'(card_irq), 0);
    rd(2, d, e); check("R4 status after ack", d, 0);
  endtask

  task automatic t_priority();
    logic [DW-1:0] d; logic e;
    @(negedge clk);
    card_in_level = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_idx = AW'(2); bus_wdata = 32'h8;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; card_in_level = 1'b0;
    check("R5 set wins over ack", DW'(card_irq), 1);
    rd(2, d, e); check("R5 status bit3 kept", d, 32'h8);
  endtask

  task automatic t_ignored();
    logic [DW-1:0] d; logic e;
    wr(1, 32'hFFFF_FFFF, e); check("R7 flash write err", DW'(e), 0);
    wr(3, 32'hFFFF_FFFF, e); check("R7 decode write err", DW'(e), 0);
    check("R7 irq unchanged", DW'(card_irq), 1);
    rd(1, d, e); check("R7 flash still 0", d, 0);
    rd(3, d, e); check("R7 decode unchanged", d, 32'h11);
    rd(2, d, e); check("R7 status unchanged", d, 32'h8);
  endtask

  task automatic t_bad();
    logic [DW-1:0] d; logic e;
    rd(5, d, e); check("R8 high index err", DW'(e), 1); check("R8 high index data", d, 0);
    wr(0, 32'h8, e); check("R8 id write err", DW'(e), 1);
    wr(10, 32'h8, e); check("R8 high write err", DW'(e), 1);
    check("R8 irq untouched", DW'(card_irq), 1);
    rd(0, d, e); check("R8 id unchanged", d, 32'h4103_4003);
    wr(2, 32'h8, e);
    check("R9 irq low after final ack", DW'(card_irq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_constants();
    t_wp();
    t_insert();
    t_priority();
    t_ignored();
    t_bad();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule